// File: doc/BRIEF.md
# Card Write CRC Status Responder

This block is the card-side data-line engine for a block write on a serial flash card bus. Once the card has finished sending its command response, the block waits for a guard interval. It then looks for the host's start bit and shifts in a data block whose size in bytes was set earlier by the set-block-length command. It then takes in the sixteen CRC bits the host appends, followed by the host's end bit.

It computes its own CRC-16 over the received data bits and compares it with the received check bits. After a short fixed turnaround it drives a framed 3-bit status token back on the data line. A matching CRC gives the positive token. The card then holds the line low as a busy indication and asks the storage array to program the block, until the array reports completion. A mismatching CRC gives the negative token. In that case nothing is programmed and the block goes back to waiting for the next write command response.

The data line is modelled as separate input, output and output-enable signals. A pad or pull-up outside the block resolves them.

Top module: `card_wr_status`

## Requirements
- R1: While reset is asserted and right after its release, dat_oe and prog_start are 0.
- R2: A low dat_in counts as the host start bit only when it is sampled more than N_WR clock cycles after the cycle in which rsp_done was sampled high. Lows sampled earlier are ignored.
- R3: After the start bit the block takes exactly 8*blk_len data bits, then 16 CRC bits most significant first, then one end bit. blk_len is in bytes, must be nonzero, and is captured in the start-bit cycle; later changes to it do not affect the current block.
- R4: The expected CRC is CRC-16 with polynomial 0x1021 (x^16+x^12+x^5+1) and initial value 0. It is computed most significant bit first over the data bits in line order, and it must equal the 16 received check bits for the block to count as good.
- R5: dat_oe stays 0 in the two cycles after the cycle in which the host end bit is sampled. It is then 1 for five cycles carrying, in order, a 0 start bit, the 3 token bits and a 1 end bit.
- R6: A good block gives token bits 0,1,0 in that order (pattern 010).
- R7: A bad block gives token bits 1,0,1 (pattern 101). After its end bit dat_oe returns to 0 and prog_start never pulses for that block.
- R8: After a positive token, the next cycle starts the busy phase: dat_oe=1 and dat_out=0, with prog_start high for exactly that first busy cycle.
- R9: The busy phase holds dat_oe=1, dat_out=0 until prog_done is sampled high. In the following cycle dat_oe is 0 and the block waits for a new rsp_done.
- R10: With no preceding rsp_done, activity on dat_in starts no reception and drives nothing on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| rsp_done | input | 1 | One-cycle pulse when the card's write command response has been sent |
| blk_len | input | LEN_W | Configured block length in bytes |
| dat_in | input | 1 | Sampled data line |
| prog_done | input | 1 | Storage array has finished programming the block |
| dat_out | output | 1 | Value driven on the data line |
| dat_oe | output | 1 | Drive enable for the data line |
| prog_start | output | 1 | One-cycle request to the array to program the received block |

## Verification
The hardest case to reach from the ports is a start bit that arrives inside the guard window after the response. It produces no visible output of its own; a receiver that accepts it only shows up later as a misaligned frame. The stimulus holds the line low during every guard cycle and follows it at once with the real start bit, so an early acceptance shifts every later bit and corrupts both the token value and its timing. The bench also covers the length being changed after the start bit, single-bit corruption placed in the data in some blocks and in the check bits in others, and line activity with no preceding response. Each case is judged by the token bits, their exact cycles and whether a busy phase follows.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  localparam logic [2:0] TOKEN_GOOD = 3'b010;
  localparam logic [2:0] TOKEN_BAD  = 3'b101;

  localparam int FRAME_W = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_GAP,
    RX_HUNT,
    RX_DATA,
    RX_CRC,
    RX_END
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_TURN,
    TX_TOKEN,
    TX_BUSY
  } tx_state_t;

endpackage

// File: rtl/wrs_crc16.sv
module wrs_crc16 #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = din ^ crc_q[W-1];
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr || en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/wrs_rx.sv
module wrs_rx
  import wrs_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int N_WR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_done,
  input  logic             accept,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             dat_in,
  output logic             blk_done,
  output logic             crc_good
);

  localparam int CNT_W = LEN_W + 3;
  localparam int GAP_W = (N_WR > 1) ? $clog2(N_WR) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(N_WR - 1);
  localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

  rx_state_t        state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CRC_W-1:0] rxcrc_q, rxcrc_d;
  logic             done_q, done_d;
  logic             good_q, good_d;
  logic [CNT_W-1:0] data_last;
  logic             crc_clr;
  logic             crc_en;
  logic [CRC_W-1:0] crc_val;

  assign data_last = {len_q, 3'b000} - CNT_W'(1);
  assign crc_clr   = (state_q == RX_HUNT) && !dat_in;
  assign crc_en    = (state_q == RX_DATA);

  wrs_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (crc_clr),
    .en   (crc_en),
    .din  (dat_in),
    .crc  (crc_val)
  );

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    bit_d   = bit_q;
    len_d   = len_q;
    rxcrc_d = rxcrc_q;
    done_d  = 1'b0;
    good_d  = good_q;
    unique case (state_q)
      RX_IDLE: begin
        if (rsp_done && accept) begin
          state_d = RX_GAP;
          gap_d   = '0;
        end
      end
      RX_GAP: begin
        if (gap_q == GAP_LAST) begin
          state_d = RX_HUNT;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      RX_HUNT: begin
        if (!dat_in) begin
          state_d = RX_DATA;
          bit_d   = '0;
          len_d   = blk_len;
        end
      end
      RX_DATA: begin
        bit_d = bit_q + CNT_W'(1);
        if (bit_q == data_last) begin
          state_d = RX_CRC;
          bit_d   = '0;
        end
      end
      RX_CRC: begin
        rxcrc_d = {rxcrc_q[CRC_W-2:0], dat_in};
        bit_d   = bit_q + CNT_W'(1);
        if (bit_q == CRC_LAST) begin
          state_d = RX_END;
        end
      end
      RX_END: begin
        done_d  = 1'b1;
        good_d  = (rxcrc_q == crc_val);
        state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      gap_q   <= '0;
      bit_q   <= '0;
      len_q   <= '0;
      rxcrc_q <= '0;
      done_q  <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      bit_q   <= bit_d;
      len_q   <= len_d;
      rxcrc_q <= rxcrc_d;
      done_q  <= done_d;
      good_q  <= good_d;
    end
  end

  assign blk_done = done_q;
  assign crc_good = good_q;

  // Block completion is a single-cycle event.
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // Completion only follows the end-bit cycle.
  assert_done_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == RX_END));

  // Start-bit hunting is reached only through the guard interval.
  assert_hunt_via_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_HUNT && $past(state_q) != RX_HUNT) |-> ($past(state_q) == RX_GAP));

endmodule

// File: rtl/wrs_tx.sv
module wrs_tx
  import wrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blk_done,
  input  logic crc_good,
  input  logic prog_done,
  output logic dat_out,
  output logic dat_oe,
  output logic prog_start,
  output logic tx_idle
);

  tx_state_t            state_q, state_d;
  logic [2:0]           idx_q, idx_d;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic                 ok_q, ok_d;
  logic                 start_q, start_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    ok_d    = ok_q;
    start_d = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (blk_done) begin
          state_d = TX_TURN;
          ok_d    = crc_good;
        end
      end
      TX_TURN: begin
        state_d = TX_TOKEN;
        idx_d   = '0;
        frame_d = ok_q ? {1'b0, TOKEN_GOOD, 1'b1} : {1'b0, TOKEN_BAD, 1'b1};
      end
      TX_TOKEN: begin
        idx_d   = idx_q + 3'd1;
        frame_d = {frame_q[FRAME_W-2:0], 1'b1};
        if (idx_q == 3'(FRAME_W - 1)) begin
          if (ok_q) begin
            state_d = TX_BUSY;
            start_d = 1'b1;
          end else begin
            state_d = TX_IDLE;
          end
        end
      end
      TX_BUSY: begin
        if (prog_done) begin
          state_d = TX_IDLE;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      frame_q <= '1;
      ok_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      frame_q <= frame_d;
      ok_q    <= ok_d;
      start_q <= start_d;
    end
  end

  assign dat_oe     = (state_q == TX_TOKEN) || (state_q == TX_BUSY);
  assign dat_out    = (state_q == TX_TOKEN) ? frame_q[FRAME_W-1] : (state_q != TX_BUSY);
  assign prog_start = start_q;
  assign tx_idle    = (state_q == TX_IDLE);

  // The cycle after a block completes is a turnaround cycle with the line released.
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !dat_oe);

  // A program request coincides with the line held low, for a good block only.
  assert_busy_after_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (dat_oe && !dat_out && ok_q));

  // A negative token is followed by a released line and no program request.
  assert_bad_no_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_TOKEN && idx_q == 3'(FRAME_W - 1) && !ok_q) |=> (!dat_oe && !start_q));

  // Completion from the array releases the line in the next cycle.
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_BUSY && prog_done) |=> !dat_oe);

endmodule

// File: rtl/card_wr_status.sv
module card_wr_status
  import wrs_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int N_WR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_done,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             dat_in,
  input  logic             prog_done,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             prog_start
);

  logic blk_done;
  logic crc_good;
  logic tx_idle;
  logic accept;

  assign accept = tx_idle && !blk_done;

  wrs_rx #(.LEN_W(LEN_W), .N_WR(N_WR)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rsp_done(rsp_done),
    .accept  (accept),
    .blk_len (blk_len),
    .dat_in  (dat_in),
    .blk_done(blk_done),
    .crc_good(crc_good)
  );

  wrs_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_done  (blk_done),
    .crc_good  (crc_good),
    .prog_done (prog_done),
    .dat_out   (dat_out),
    .dat_oe    (dat_oe),
    .prog_start(prog_start),
    .tx_idle   (tx_idle)
  );

  // Nothing is driven on the line out of reset.
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dat_oe && !prog_start));

endmodule

// File: tb/card_wr_status_bench.sv
`timescale 1ns/1ps
module card_wr_status_bench;

  localparam int LEN_W = 12;
  localparam int N_WR  = 2;

  logic             clk;
  logic             rst_n;
  logic             rsp_done;
  logic [LEN_W-1:0] blk_len;
  logic             dat_in;
  logic             prog_done;
  logic             dat_out;
  logic             dat_oe;
  logic             prog_start;

  int total;
  int bad;
  int cyc;
  int pstart_cnt;

  card_wr_status #(.LEN_W(LEN_W), .N_WR(N_WR)) u_card_wr_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_done  (rsp_done),
    .blk_len   (blk_len),
    .dat_in    (dat_in),
    .prog_done (prog_done),
    .dat_out   (dat_out),
    .dat_oe    (dat_oe),
    .prog_start(prog_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (prog_start) pstart_cnt <= pstart_cnt + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int nbits, input logic [63:0] bits);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < nbits; i++) begin
      logic fb = bits[63-i] ^ c[15];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic run_block(input int len, input int pat, input bit corrupt,
                           input bit early, input int pre, input bit swaplen,
                           input int busy_len);
    logic [63:0] dbits;
    logic [15:0] crc;
    logic [4:0]  frame;
    int          p0;
    dbits = '0;
    for (int k = 0; k < 8; k++) begin
      if (pat == 0)      dbits[63-8*k -: 8] = 8'h00;
      else if (pat == 1) dbits[63-8*k -: 8] = 8'hFF;
      else               dbits[63-8*k -: 8] = 8'(pat*73 + k*29 + len*5 + 17);
    end
    crc = crc_of(len*8, dbits);
    if (corrupt) begin
      if (pat % 2 == 1) dbits[63 - (len*8 - 1)] = ~dbits[63 - (len*8 - 1)];
      else              crc[pat % 16] = ~crc[pat % 16];
    end
    frame = corrupt ? 5'b01011 : 5'b00101;
    p0 = pstart_cnt;

    blk_len  = LEN_W'(len);
    rsp_done = 1'b1;
    step();
    rsp_done = 1'b0;
    for (int g = 0; g < N_WR; g++) begin
      dat_in = early ? 1'b0 : 1'b1;   // R2: lows inside the guard are ignored
      step();
    end
    for (int g = 0; g < pre; g++) begin
      dat_in = 1'b1;
      step();
    end
    dat_in = 1'b0;
    step();
    if (swaplen) blk_len = LEN_W'(len + 3);   // R3: length captured at start bit
    for (int i = 0; i < len*8; i++) begin
      dat_in = dbits[63-i];
      step();
    end
    for (int i = 15; i >= 0; i--) begin
      dat_in = crc[i];
      step();
    end
    dat_in = 1'b1;
    step();
    // now just after the edge that sampled the end bit
    chk("R5 turnaround cycle 1 oe", dat_oe, 0);
    step();
    chk("R5 turnaround cycle 2 oe", dat_oe, 0);
    step();
    for (int i = 0; i < 5; i++) begin
      chk(corrupt ? "R7 token frame oe" : "R6 token frame oe", dat_oe, 1);
      chk(corrupt ? "R7 token frame bit" : "R6 token frame bit", dat_out, frame[4-i]);
      step();
    end
    if (!corrupt) begin
      chk("R8 busy oe", dat_oe, 1);
      chk("R8 busy line low", dat_out, 0);
      chk("R8 prog_start first busy cycle", prog_start, 1);
      for (int b = 0; b < busy_len; b++) begin
        step();
        chk("R9 busy held", {dat_oe, dat_out, prog_start}, 3'b100);
      end
      prog_done = 1'b1;
      step();
      prog_done = 1'b0;
      chk("R9 released after prog_done", dat_oe, 0);
      chk("R8 one program request", pstart_cnt - p0, 1);
    end else begin
      chk("R7 released after negative token", dat_oe, 0);
      for (int b = 0; b < 3; b++) begin
        step();
        chk("R7 line stays released", dat_oe, 0);
      end
      chk("R7 no program request", pstart_cnt - p0, 0);
    end
    blk_len = LEN_W'(len);
  endtask

  initial begin
    total      = 0;
    bad        = 0;
    cyc        = 0;
    pstart_cnt = 0;
    rst_n      = 1'b0;
    rsp_done   = 1'b0;
    blk_len    = LEN_W'(1);
    dat_in     = 1'b1;
    prog_done  = 1'b0;
    step();
    chk("R1 reset oe", dat_oe, 0);
    chk("R1 reset prog_start", prog_start, 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 after release oe", dat_oe, 0);
    chk("R1 after release prog_start", prog_start, 0);

    // R10: line activity with no response pulse
    for (int i = 0; i < 40; i++) begin
      dat_in = (i % 3 == 0) ? 1'b0 : ((i > 20) ? 1'b0 : 1'b1);
      step();
      chk("R10 no drive without rsp_done", dat_oe, 0);
    end
    dat_in = 1'b1;
    step();

    // R3 R4 R6 R7 R8 R9 sweep over length, data pattern and corruption
    for (int len = 1; len <= 4; len++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int c = 0; c < 2; c++) begin
          run_block(len, pat, c[0], pat == 2, pat % 3, pat == 3, len);
        end
      end
    end

    // R2: guard lows followed at once by the real start bit, longer block
    run_block(8, 5, 1'b0, 1'b1, 0, 1'b0, 0);
    run_block(8, 6, 1'b1, 1'b1, 0, 1'b1, 0);

    // R10 after traffic: stray lows do not start a reception
    for (int i = 0; i < 30; i++) begin
      dat_in = i[0];
      step();
      chk("R10 idle after traffic", dat_oe, 0);
    end
    dat_in = 1'b1;
    run_block(2, 7, 1'b0, 1'b0, 1, 1'b0, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule